// File: doc/BRIEF.md
# Packed Unpack-Interleave Execution Unit

This unit executes the 64-bit packed unpack-and-interleave operations in one clock. The second opcode byte that follows the two-byte escape picks the element width (8, 16 or 32 bits) and which 32-bit half of the two sources is used. The chosen elements of the first source and the second source are then woven together into a registered 64-bit result. An issue stage presents one operation per cycle on `valid_i`. One cycle later the unit returns either a result on `valid_o` or a single exception code on `exc_valid_o`.

Before any result is written, the unit checks the conditions that stop this instruction class from executing: the emulation-enable bit, the feature-present indication, the task-switched bit and a pending unmasked floating-point error. Memory-side faults from the stack, segment, paging or alignment logic are detected upstream and arrive as flags. The unit folds all of these into one prioritized code. A faulting operation leaves the result register unchanged. No flags are produced.

Top module: `unpack_unit`

## Requirements
- R1: Opcode bytes select the operation: 60h is low bytes, 61h is low words, 62h is low doublewords, 69h is high words and 6Ah is high doublewords. Every other byte value is rejected with exception code 1.
- R2: Output element pair k holds, in its lower position, element k of the chosen half of `src_a_i` and, in its upper position, element k of the chosen half of `src_b_i`.
- R3: Low operations take elements only from bits 31:0 of each source, and high operations only from bits 63:32. The other half has no effect on the result. This also holds when `b_is_mem_i` marks a memory operand.
- R4: When `src_b_i` is zero, each chosen element of `src_a_i` appears zero-extended to twice its width.
- R5: An accepted operation with no fault raises `valid_o` for exactly the following cycle, with `result_o` updated in that same cycle.
- R6: Exception codes are: 1 invalid opcode (emulation bit set, feature absent, or unknown opcode), 2 device not available (task-switched bit set), 3 pending floating-point error, 4 stack fault, 5 general protection, 6 page fault, 7 alignment. The memory flags `mem_flt_i` bits 0..3 map to codes 4..7, and they count only when `b_is_mem_i` is 1.
- R7: When several conditions hold at once, the lowest nonzero code is reported.
- R8: A faulting operation raises `exc_valid_o` for the following cycle only, with `valid_o` low and `result_o` unchanged.
- R9: In a cycle without `valid_i`, both valid outputs are low in the next cycle and `result_o` is held. `exc_code_o` reads 0 whenever `exc_valid_o` is low.
- R10: After reset, `valid_o`, `exc_valid_o`, `exc_code_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation presented this cycle |
| opcode_i | input | 8 | Second opcode byte after the escape |
| src_a_i | input | 64 | First source, also the destination value |
| src_b_i | input | 64 | Second source, register or memory data |
| b_is_mem_i | input | 1 | Second source comes from memory |
| emu_en_i | input | 1 | Emulation-enable control bit |
| feat_ok_i | input | 1 | Packed-integer feature present |
| task_sw_i | input | 1 | Task-switched control bit |
| fp_pend_i | input | 1 | Unmasked floating-point error pending |
| mem_flt_i | input | 4 | Memory faults: bit0 stack, bit1 general protection, bit2 page, bit3 alignment |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered interleaved result |
| exc_valid_o | output | 1 | Exception reported instead of a result |
| exc_code_o | output | 3 | Prioritized exception code |

## Verification
The inline assertions check the cycle-level behaviour on every cycle. They confirm that the two valid outputs never rise together, that a fault or an idle cycle leaves the result untouched, that the code is nonzero exactly when an exception is flagged, and that the invalid-opcode conditions always win over every other fault. The exact interleave ordering, the handling of the ignored half, the zero-extension case and the full priority ladder across combinations of faults are shown only by the bench scenarios. Those scenarios compare every output, every cycle, against a behavioural model.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  typedef enum logic [1:0] {ESZ_B = 2'd0, ESZ_W = 2'd1, ESZ_D = 2'd2} esz_e;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_BADOP = 3'd1,
    EXC_NODEV = 3'd2,
    EXC_FPERR = 3'd3,
    EXC_STACK = 3'd4,
    EXC_GPROT = 3'd5,
    EXC_PAGE  = 3'd6,
    EXC_ALIGN = 3'd7
  } exc_e;

  localparam int unsigned MEM_FLT_W = 4;
  localparam int unsigned NUM_ESZ   = 3;
endpackage

// File: rtl/unpack_decode.sv
module unpack_decode
  import unpack_pkg::*;
(
  input  logic [7:0] opcode_i,
  output esz_e       esz_o,
  output logic       hi_o,
  output logic       known_o
);
  always_comb begin
    esz_o   = ESZ_B;
    hi_o    = 1'b0;
    known_o = 1'b1;
    unique case (opcode_i)
      8'h60: begin esz_o = ESZ_B; hi_o = 1'b0; end
      8'h61: begin esz_o = ESZ_W; hi_o = 1'b0; end
      8'h62: begin esz_o = ESZ_D; hi_o = 1'b0; end
      8'h69: begin esz_o = ESZ_W; hi_o = 1'b1; end
      8'h6A: begin esz_o = ESZ_D; hi_o = 1'b1; end
      default: known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/unpack_lane_mix.sv
module unpack_lane_mix #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ELEM_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              hi_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned NPAIR  = HALF_W / ELEM_W;

  logic [HALF_W-1:0] a_h, b_h;
  assign a_h = hi_i ? a_i[DATA_W-1:HALF_W] : a_i[HALF_W-1:0];
  assign b_h = hi_i ? b_i[DATA_W-1:HALF_W] : b_i[HALF_W-1:0];

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    // first source takes the lower slot of each pair
    assign y_o[(2*k)*ELEM_W   +: ELEM_W] = a_h[k*ELEM_W +: ELEM_W];
    assign y_o[(2*k+1)*ELEM_W +: ELEM_W] = b_h[k*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/unpack_fault_arb.sv
module unpack_fault_arb
  import unpack_pkg::*;
(
  input  logic                 known_i,
  input  logic                 emu_en_i,
  input  logic                 feat_ok_i,
  input  logic                 task_sw_i,
  input  logic                 fp_pend_i,
  input  logic                 b_is_mem_i,
  input  logic [MEM_FLT_W-1:0] mem_flt_i,
  output exc_e                 code_o
);
  logic [MEM_FLT_W-1:0] mflt;
  assign mflt = b_is_mem_i ? mem_flt_i : '0;

  always_comb begin
    if (emu_en_i || !feat_ok_i || !known_i) code_o = EXC_BADOP;
    else if (task_sw_i)                     code_o = EXC_NODEV;
    else if (fp_pend_i)                     code_o = EXC_FPERR;
    else if (mflt[0])                       code_o = EXC_STACK;
    else if (mflt[1])                       code_o = EXC_GPROT;
    else if (mflt[2])                       code_o = EXC_PAGE;
    else if (mflt[3])                       code_o = EXC_ALIGN;
    else                                    code_o = EXC_NONE;
  end
endmodule

// File: rtl/unpack_unit.sv
module unpack_unit
  import unpack_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [7:0]           opcode_i,
  input  logic [DATA_W-1:0]    src_a_i,
  input  logic [DATA_W-1:0]    src_b_i,
  input  logic                 b_is_mem_i,
  input  logic                 emu_en_i,
  input  logic                 feat_ok_i,
  input  logic                 task_sw_i,
  input  logic                 fp_pend_i,
  input  logic [MEM_FLT_W-1:0] mem_flt_i,
  output logic                 valid_o,
  output logic [DATA_W-1:0]    result_o,
  output logic                 exc_valid_o,
  output logic [2:0]           exc_code_o
);
  esz_e esz;
  logic hi, known;
  exc_e code;
  logic [DATA_W-1:0] mix [NUM_ESZ];
  logic [DATA_W-1:0] mix_sel;

  unpack_decode u_dec (
    .opcode_i (opcode_i),
    .esz_o    (esz),
    .hi_o     (hi),
    .known_o  (known)
  );

  for (genvar g = 0; g < NUM_ESZ; g++) begin : g_esz
    unpack_lane_mix #(.DATA_W(DATA_W), .ELEM_W(8 << g)) u_mix (
      .a_i  (src_a_i),
      .b_i  (src_b_i),
      .hi_i (hi),
      .y_o  (mix[g])
    );
  end

  always_comb begin
    case (esz)
      ESZ_W:   mix_sel = mix[1];
      ESZ_D:   mix_sel = mix[2];
      default: mix_sel = mix[0];
    endcase
  end

  unpack_fault_arb u_arb (
    .known_i    (known),
    .emu_en_i   (emu_en_i),
    .feat_ok_i  (feat_ok_i),
    .task_sw_i  (task_sw_i),
    .fp_pend_i  (fp_pend_i),
    .b_is_mem_i (b_is_mem_i),
    .mem_flt_i  (mem_flt_i),
    .code_o     (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      exc_valid_o <= 1'b0;
      exc_code_o  <= EXC_NONE;
      result_o    <= '0;
    end else begin
      valid_o     <= 1'b0;
      exc_valid_o <= 1'b0;
      exc_code_o  <= EXC_NONE;
      if (valid_i) begin
        if (code != EXC_NONE) begin
          exc_valid_o <= 1'b1;
          exc_code_o  <= code;
        end else begin
          valid_o  <= 1'b1;
          result_o <= mix_sel;
        end
      end
    end
  end

  // R8: result and exception outputs are exclusive
  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && exc_valid_o));

  assert_hold_on_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> $stable(result_o));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !exc_valid_o && $stable(result_o)));

  assert_code_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o == (exc_code_o != 3'd0)));

  assert_badop_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (emu_en_i || !feat_ok_i)) |=> (exc_valid_o && exc_code_o == 3'd1));

  assert_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
endmodule

// File: tb/unpack_unit_tb.sv
module unpack_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0;
  logic        b_is_mem_i = 1'b0, emu_en_i = 1'b0, feat_ok_i = 1'b1;
  logic        task_sw_i = 1'b0, fp_pend_i = 1'b0;
  logic [3:0]  mem_flt_i = '0;
  logic        valid_o, exc_valid_o;
  logic [63:0] result_o;
  logic [2:0]  exc_code_o;

  int n_chk = 0, n_fail = 0;
  logic        e_valid = 0, e_exc = 0;
  logic [2:0]  e_code = 0;
  logic [63:0] e_res = 0;
  string       tag = "R10";

  always #2.5 clk_i = ~clk_i;

  unpack_unit u_dut (.*);

  function automatic logic [63:0] ref_mix(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
    int ew, base;
    logic [63:0] r;
    ew = (op == 8'h60) ? 8 : (op == 8'h61 || op == 8'h69) ? 16 : 32;
    base = (op == 8'h69 || op == 8'h6A) ? 32 : 0;
    for (int t = 0; t < 64; t++) begin
      int j, sb;
      j  = t / ew;
      sb = base + (j / 2) * ew + (t % ew);
      r[t] = (j % 2) ? b[sb] : a[sb];
    end
    return r;
  endfunction

  function automatic logic [2:0] ref_code();
    logic known;
    known = (opcode_i == 8'h60 || opcode_i == 8'h61 || opcode_i == 8'h62 ||
             opcode_i == 8'h69 || opcode_i == 8'h6A);
    if (emu_en_i || !feat_ok_i || !known) return 3'd1;
    if (task_sw_i) return 3'd2;
    if (fp_pend_i) return 3'd3;
    if (b_is_mem_i) begin
      for (int i = 0; i < 4; i++) if (mem_flt_i[i]) return 3'(4 + i);
    end
    return 3'd0;
  endfunction

  task automatic compare();
    n_chk++;
    if (valid_o !== e_valid || exc_valid_o !== e_exc || exc_code_o !== e_code || result_o !== e_res) begin
      n_fail++;
      $display("FAIL %s: got v=%b e=%b c=%0d r=%h exp v=%b e=%b c=%0d r=%h", tag,
               valid_o, exc_valid_o, exc_code_o, result_o, e_valid, e_exc, e_code, e_res);
    end
  endtask

  // drive at negedge, predict, compare at next negedge
  task automatic step(input string t);
    logic [2:0] c;
    tag = t;
    c = ref_code();
    e_valid = valid_i && c == 0;
    e_exc   = valid_i && c != 0;
    e_code  = valid_i ? c : 3'd0;
    if (e_valid) e_res = ref_mix(opcode_i, src_a_i, src_b_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic clear_ctl();
    b_is_mem_i = 0; emu_en_i = 0; feat_ok_i = 1; task_sw_i = 0; fp_pend_i = 0; mem_flt_i = 0;
  endtask

  task automatic issue(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b, input string t);
    valid_i = 1; opcode_i = op; src_a_i = a; src_b_i = b;
    step(t);
  endtask

  initial begin
    automatic logic [7:0] ops[5] = '{8'h60, 8'h61, 8'h62, 8'h69, 8'h6A};
    repeat (3) @(negedge clk_i);
    compare(); // R10 reset state
    rst_ni = 1;
    @(negedge clk_i);
    compare();

    // R2: random interleave per opcode
    foreach (ops[i]) for (int n = 0; n < 40; n++)
      issue(ops[i], {$urandom, $urandom}, {$urandom, $urandom}, "R2");
    issue(8'h60, 64'h8877665544332211, 64'hFFEEDDCCBBAA9988, "R2");
    issue(8'h6A, 64'h8877665544332211, 64'hFFEEDDCCBBAA9988, "R2");

    // R3: unused half varies, memory operand too
    foreach (ops[i]) for (int n = 0; n < 8; n++) begin
      b_is_mem_i = n[0];
      issue(ops[i], {$urandom, 32'h01234567}, {$urandom, 32'h89ABCDEF}, "R3");
    end
    b_is_mem_i = 0;

    // R4: zero second source
    foreach (ops[i]) issue(ops[i], 64'hF1E2D3C4B5A69788, 64'h0, "R4");

    // R9: idle cycles hold result
    valid_i = 0; src_a_i = '1; src_b_i = '1;
    repeat (3) step("R9");

    // R1: full opcode sweep
    for (int o = 0; o < 256; o++) issue(8'(o), {$urandom, $urandom}, {$urandom, $urandom}, "R1");

    // R6/R7/R8: fault combinations
    for (int m = 0; m < 256; m++) begin
      {emu_en_i, feat_ok_i, task_sw_i, fp_pend_i, mem_flt_i} = 8'(m) ^ 8'h40;
      b_is_mem_i = 1;
      issue(ops[m % 5], {$urandom, $urandom}, {$urandom, $urandom}, "R7");
      b_is_mem_i = 0;
      issue(ops[m % 5], {$urandom, $urandom}, {$urandom, $urandom}, "R6");
      clear_ctl();
      issue(ops[m % 5], {$urandom, $urandom}, {$urandom, $urandom}, "R5");
    end
    valid_i = 0;
    step("R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule